// File: doc/BRIEF.md
# One-Bit MAC Table Ager

This block keeps a forwarding table from filling with stale addresses. A prescaler turns the core clock into a programmable time unit. A period counter groups a number of those units into one aging period. When a period ends, a sweep engine walks the whole table once, one entry per granted clock.

The block keeps a single age bit per entry. The bit is set on the first sweep that finds the entry idle and cleared whenever forwarding logic reports a hit on that entry. An entry that is still marked when the next sweep reaches it is invalidated. An address therefore disappears between one and two periods after its last use, so the configured age is halved to get the period.

Locked (static) entries are never touched. The table storage itself lives outside the block. The ager reads an entry's valid and locked flags through a request/grant port and raises a clear strobe to invalidate it. When the grant is withdrawn for a host command, the sweep simply waits on the same index.

Top module: `mac_ager`

## Requirements
- R1: The unit-size code `cfg_unit` selects the time unit. Outside test mode, codes 0, 1, 2 and 3 mean 100 us, 1 ms, 10 ms and 100 ms at `CLK_HZ`. In test mode, code c means `TEST_UNIT_CYC << c` clock cycles.
- R2: The aging period is max(1, `cfg_age`) / 2 units, rounded down. A resulting period of 0 (cfg_age of 0 or 1) disables aging, and no sweep ever starts.
- R3: With aging enabled, a sweep starts once every period; consecutive rises of `tbl_req` are exactly one period apart. Within a sweep, entries are visited in ascending index order from 0 to ENTRIES-1, each exactly once.
- R4: A visited entry that is valid, unlocked and has its age bit clear gets its age bit (`age_o[i]`) set.
- R5: A visited entry that is valid, unlocked and has its age bit set is invalidated. The block asserts `tbl_clr` with `tbl_idx` equal to the entry, and the age bit returns to 0.
- R6: A locked entry is never cleared, and its age bit is held at 0. An invalid entry is not cleared either, and its age bit is also held at 0.
- R7: A refresh strobe (`ref_vld` with `ref_idx`) clears that entry's age bit at the next clock edge. If it coincides with the sweep visiting the same entry, the refresh wins and no clear is issued.
- R8: While `tbl_req` is high and `tbl_gnt` is low, `tbl_idx` holds and `tbl_clr` stays low. The sweep resumes at the same index once the grant returns.
- R9: After reset, `tbl_req` and `tbl_clr` are low and all age bits are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_unit | input | 2 | Time-unit size code |
| cfg_age | input | AGE_W | Requested total age in units |
| ref_vld | input | 1 | Refresh strobe from a forwarding hit |
| ref_idx | input | IDX_W | Entry index of the refresh |
| tbl_req | output | 1 | Sweep requests the table port |
| tbl_gnt | input | 1 | Table port granted this cycle |
| tbl_idx | output | IDX_W | Entry index being visited |
| tbl_rd_valid | input | 1 | Valid flag of entry `tbl_idx` (combinational read) |
| tbl_rd_locked | input | 1 | Locked flag of entry `tbl_idx` (combinational read) |
| tbl_clr | output | 1 | Invalidate entry `tbl_idx` at this clock edge |
| age_o | output | ENTRIES | Age bit of each entry |

## Verification
The sweep starts one cycle after each period expiry. The bench does not predict that absolute cycle; it measures the distance between successive rises of `tbl_req`, which must equal the period in cycles exactly. `tbl_clr` is valid in the same cycle as the granted visit, so the scoreboard monitor compares it against the queued expected index at the falling edge of that cycle. Refresh effects and end-of-sweep age bits are registered one edge after the event. The driver therefore reads them one time step after the following rising edge.

// File: rtl/mac_ager_pkg.sv
// Shared definitions for the MAC table ager.
// Assumes clk_hz is a multiple of 10 kHz for exact unit lengths.
package mac_ager_pkg;

    typedef enum logic [1:0] {
        UNIT_100US = 2'd0,
        UNIT_1MS   = 2'd1,
        UNIT_10MS  = 2'd2,
        UNIT_100MS = 2'd3
    } unit_code_e;

    // Clock cycles in one time unit for a given size code.
    function automatic logic [31:0] unit_cycles(input logic [1:0] code,
                                                input int unsigned clk_hz,
                                                input int unsigned test_mode,
                                                input int unsigned test_cyc);
        logic [31:0] base;
        if (test_mode != 0) begin
            return 32'(test_cyc) << code;
        end
        base = 32'(clk_hz / 10000);
        case (unit_code_e'(code))
            UNIT_100US: return base;
            UNIT_1MS:   return base * 32'd10;
            UNIT_10MS:  return base * 32'd100;
            default:    return base * 32'd1000;
        endcase
    endfunction

endpackage

// File: rtl/mac_ager_tick.sv
// Unit prescaler: emits a one-cycle pulse once per selected time unit.
// Assumes every unit is at least two cycles long.
// The count restarts whenever aging is disabled.
module mac_ager_tick #(
    parameter int CLK_HZ        = 125_000_000,
    parameter int TEST_MODE     = 0,
    parameter int TEST_UNIT_CYC = 2,
    parameter int CNT_W         = 32
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       en,
    input  logic [1:0] unit_code,
    output logic       unit_tick
);
    import mac_ager_pkg::*;

    localparam int NUM_CODES = 4;

    logic [CNT_W-1:0] lim_tab [NUM_CODES];
    logic [CNT_W-1:0] lim;
    logic [CNT_W-1:0] cnt_q;

    // One constant limit per size code.
    for (genvar c = 0; c < NUM_CODES; c++) begin : g_lim
        assign lim_tab[c] = CNT_W'(unit_cycles(2'(c), CLK_HZ, TEST_MODE, TEST_UNIT_CYC));
    end

    // Pick the limit of the active code.
    always_comb lim = lim_tab[unit_code];

    // Count cycles and pulse at the end of each unit.
    always_ff @(posedge clk) begin
        if (!rst_n || !en) begin
            cnt_q     <= '0;
            unit_tick <= 1'b0;
        end else if (cnt_q >= lim - CNT_W'(1)) begin
            cnt_q     <= '0;
            unit_tick <= 1'b1;
        end else begin
            cnt_q     <= cnt_q + CNT_W'(1);
            unit_tick <= 1'b0;
        end
    end

    p_tick_single_r1: assert property (@(posedge clk) disable iff (!rst_n)
        unit_tick |=> !unit_tick)
        else $error("unit tick longer than one cycle");

endmodule

// File: rtl/mac_ager_period.sv
// Period counter: turns requested age into a period of units and pulses at expiry.
// One age bit needs two periods, so period = max(1, age) / 2.
// A period of zero disables aging.
module mac_ager_period #(
    parameter int AGE_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [AGE_W-1:0] age_units,
    input  logic             unit_tick,
    output logic             en,
    output logic             expire
);
    logic [AGE_W-1:0] age_floor;
    logic [AGE_W-1:0] period;
    logic [AGE_W-1:0] ucnt_q;

    // Clamp the requested age and halve it for one-bit aging.
    always_comb begin
        age_floor = (age_units == '0) ? AGE_W'(1) : age_units;
        period    = age_floor >> 1;
        en        = (period != '0);
    end

    // Count units and flag the end of each period.
    always_ff @(posedge clk) begin
        if (!rst_n || !en) begin
            ucnt_q <= '0;
            expire <= 1'b0;
        end else if (unit_tick) begin
            if (ucnt_q >= period - AGE_W'(1)) begin
                ucnt_q <= '0;
                expire <= 1'b1;
            end else begin
                ucnt_q <= ucnt_q + AGE_W'(1);
                expire <= 1'b0;
            end
        end else begin
            expire <= 1'b0;
        end
    end

    p_off_no_expire_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !en |=> !expire)
        else $error("expiry while aging disabled");

    p_expire_on_unit_r3: assert property (@(posedge clk) disable iff (!rst_n)
        expire |-> $past(unit_tick))
        else $error("expiry without a unit tick");

endmodule

// File: rtl/mac_ager_sweep.sv
// Sweep engine: holds one age bit per entry and walks the table once per expiry.
// Assumes the table returns the valid and locked flags combinationally
// for tbl_idx, and that it applies tbl_clr at the clock edge.
// An expiry that arrives mid-sweep is held and starts another sweep.
module mac_ager_sweep #(
    parameter int ENTRIES = 16,
    parameter int IDX_W   = $clog2(ENTRIES)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               expire,
    input  logic               ref_vld,
    input  logic [IDX_W-1:0]   ref_idx,
    input  logic               tbl_gnt,
    input  logic               tbl_rd_valid,
    input  logic               tbl_rd_locked,
    output logic               tbl_req,
    output logic [IDX_W-1:0]   tbl_idx,
    output logic               tbl_clr,
    output logic [ENTRIES-1:0] age_o
);
    localparam logic [IDX_W-1:0] LAST = IDX_W'(ENTRIES - 1);

    logic               busy_q;
    logic               pend_q;
    logic [IDX_W-1:0]   idx_q;
    logic [ENTRIES-1:0] age_q;
    logic               visit;
    logic               ref_hit;

    // Decode the current visit and whether it removes the entry.
    always_comb begin
        visit   = busy_q && tbl_gnt;
        ref_hit = ref_vld && (ref_idx == idx_q);
        tbl_clr = visit && tbl_rd_valid && !tbl_rd_locked && age_q[idx_q] && !ref_hit;
        tbl_req = busy_q;
        tbl_idx = idx_q;
        age_o   = age_q;
    end

    // Walk control: start on expiry, advance on grant, chain a held expiry.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy_q <= 1'b0;
            pend_q <= 1'b0;
            idx_q  <= '0;
        end else if (visit && idx_q == LAST) begin
            busy_q <= pend_q || expire;
            pend_q <= 1'b0;
            idx_q  <= '0;
        end else begin
            if (visit) begin
                idx_q <= idx_q + IDX_W'(1);
            end
            if (expire) begin
                if (busy_q) begin
                    pend_q <= 1'b1;
                end else begin
                    busy_q <= 1'b1;
                end
            end
        end
    end

    // Per-entry age bit: a refresh clears it, a visit marks or removes.
    for (genvar g = 0; g < ENTRIES; g++) begin : g_age
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                age_q[g] <= 1'b0;
            end else if (ref_vld && ref_idx == IDX_W'(g)) begin
                age_q[g] <= 1'b0;
            end else if (visit && idx_q == IDX_W'(g)) begin
                age_q[g] <= tbl_rd_valid && !tbl_rd_locked && !age_q[g];
            end
        end
    end

    p_idx_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (tbl_req && !tbl_gnt) |=> (tbl_req && tbl_idx == $past(tbl_idx)))
        else $error("index moved while not granted");

    p_no_clr_stall_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !tbl_gnt |-> !tbl_clr)
        else $error("clear without grant");

    p_clr_unlocked_r6: assert property (@(posedge clk) disable iff (!rst_n)
        tbl_clr |-> (tbl_rd_valid && !tbl_rd_locked))
        else $error("clear of locked or invalid entry");

    p_clr_drops_age_r5: assert property (@(posedge clk) disable iff (!rst_n)
        tbl_clr |=> !age_o[$past(tbl_idx)])
        else $error("age bit kept after clear");

    p_locked_age_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (tbl_req && tbl_gnt && tbl_rd_locked) |=> !age_o[$past(tbl_idx)])
        else $error("locked entry marked");

    p_refresh_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (ref_vld && int'(ref_idx) < ENTRIES) |=> !age_o[$past(ref_idx)])
        else $error("refresh did not clear age bit");

    p_idle_idx_r3: assert property (@(posedge clk) disable iff (!rst_n)
        !tbl_req |-> (tbl_idx == '0))
        else $error("idle sweep not parked at index 0");

endmodule

// File: rtl/mac_ager.sv
// One-bit MAC table ager: prescaler, period counter and sweep engine.
// The table storage and the arbiter that drives tbl_gnt are outside.
module mac_ager #(
    parameter int ENTRIES       = 16,
    parameter int AGE_W         = 16,
    parameter int CLK_HZ        = 125_000_000,
    parameter int TEST_MODE     = 0,
    parameter int TEST_UNIT_CYC = 2,
    localparam int IDX_W        = $clog2(ENTRIES)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [1:0]         cfg_unit,
    input  logic [AGE_W-1:0]   cfg_age,
    input  logic               ref_vld,
    input  logic [IDX_W-1:0]   ref_idx,
    output logic               tbl_req,
    input  logic               tbl_gnt,
    output logic [IDX_W-1:0]   tbl_idx,
    input  logic               tbl_rd_valid,
    input  logic               tbl_rd_locked,
    output logic               tbl_clr,
    output logic [ENTRIES-1:0] age_o
);
    logic age_en;
    logic unit_tick;
    logic expire;

    mac_ager_tick #(
        .CLK_HZ        (CLK_HZ),
        .TEST_MODE     (TEST_MODE),
        .TEST_UNIT_CYC (TEST_UNIT_CYC),
        .CNT_W         (32)
    ) u_tick (
        .clk       (clk),
        .rst_n     (rst_n),
        .en        (age_en),
        .unit_code (cfg_unit),
        .unit_tick (unit_tick)
    );

    mac_ager_period #(
        .AGE_W (AGE_W)
    ) u_period (
        .clk       (clk),
        .rst_n     (rst_n),
        .age_units (cfg_age),
        .unit_tick (unit_tick),
        .en        (age_en),
        .expire    (expire)
    );

    mac_ager_sweep #(
        .ENTRIES (ENTRIES),
        .IDX_W   (IDX_W)
    ) u_sweep (
        .clk           (clk),
        .rst_n         (rst_n),
        .expire        (expire),
        .ref_vld       (ref_vld),
        .ref_idx       (ref_idx),
        .tbl_gnt       (tbl_gnt),
        .tbl_rd_valid  (tbl_rd_valid),
        .tbl_rd_locked (tbl_rd_locked),
        .tbl_req       (tbl_req),
        .tbl_idx       (tbl_idx),
        .tbl_clr       (tbl_clr),
        .age_o         (age_o)
    );

endmodule

// File: tb/mac_ager_tb.sv
`timescale 1ns/1ps
module mac_ager_tb;
    localparam int N      = 8;
    localparam int IW     = 3;
    localparam int AW     = 16;
    localparam int TUC    = 2;
    localparam int WDOG   = 20000;

    logic          clk = 1'b0;
    logic          rst_n;
    logic [1:0]    cfg_unit;
    logic [AW-1:0] cfg_age;
    logic          ref_vld;
    logic [IW-1:0] ref_idx;
    logic          tbl_req;
    logic          tbl_gnt;
    logic [IW-1:0] tbl_idx;
    logic          tbl_rd_valid;
    logic          tbl_rd_locked;
    logic          tbl_clr;
    logic [N-1:0]  age_o;

    // table model owned by the bench
    logic [N-1:0]  mv;
    logic [N-1:0]  ml;
    logic [N-1:0]  ld_v;
    logic          ld_go;

    int checks   = 0;
    int failures = 0;
    int cyc      = 0;
    int n_rise   = 0;
    int last_rise = 0;
    int prev_rise = 0;
    logic prev_req = 1'b0;
    int exp_q[$];
    int visit_q[$];

    always #4 clk = ~clk;

    mac_ager #(
        .ENTRIES(N), .AGE_W(AW), .CLK_HZ(125_000_000),
        .TEST_MODE(1), .TEST_UNIT_CYC(TUC)
    ) u_dut (
        .clk(clk), .rst_n(rst_n), .cfg_unit(cfg_unit), .cfg_age(cfg_age),
        .ref_vld(ref_vld), .ref_idx(ref_idx), .tbl_req(tbl_req),
        .tbl_gnt(tbl_gnt), .tbl_idx(tbl_idx), .tbl_rd_valid(tbl_rd_valid),
        .tbl_rd_locked(tbl_rd_locked), .tbl_clr(tbl_clr), .age_o(age_o)
    );

    assign tbl_rd_valid  = mv[tbl_idx];
    assign tbl_rd_locked = ml[tbl_idx];

    // table storage: load on request, invalidate on clear
    always @(posedge clk) begin
        if (ld_go) mv <= ld_v;
        else if (tbl_clr) mv[tbl_idx] <= 1'b0;
    end

    // cycle counter and watchdog
    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (cyc > WDOG) begin
            failures = failures + 1;
            $display("FAIL watchdog expired at cycle %0d", cyc);
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    // monitor: sweep starts, visit order, clears against the scoreboard
    always @(negedge clk) begin
        if (rst_n) begin
            if (tbl_req && !prev_req) begin
                n_rise    = n_rise + 1;
                prev_rise = last_rise;
                last_rise = cyc;
            end
            prev_req = tbl_req;
            if (tbl_req && tbl_gnt) visit_q.push_back(int'(tbl_idx));
            if (tbl_clr) begin
                checks = checks + 1;
                if (exp_q.size() == 0) begin
                    failures = failures + 1;
                    $display("FAIL R5 unexpected clear: actual idx=%0d expected none", tbl_idx);
                end else begin
                    int e;
                    e = exp_q.pop_front();
                    if (int'(tbl_idx) != e) begin
                        failures = failures + 1;
                        $display("FAIL R5 clear index: actual=%0d expected=%0d", tbl_idx, e);
                    end
                end
            end
        end
    end

    task automatic step(input int n = 1);
        for (int i = 0; i < n; i++) begin
            @(posedge clk);
            #1;
        end
    endtask

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks = checks + 1;
        if (!ok) begin
            failures = failures + 1;
            $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic measure(input logic [1:0] code, input int age, input int exp_cyc, input string req);
        int r0;
        cfg_unit = code;
        cfg_age  = AW'(age);
        step(2);
        r0 = n_rise;
        while (n_rise < r0 + 3) step();
        chk((last_rise - prev_rise) == exp_cyc, req, last_rise - prev_rise, exp_cyc);
    endtask

    task automatic wait_sweep();
        while (!tbl_req) step();
        while (tbl_req) step();
    endtask

    task automatic refresh(input int idx);
        ref_vld = 1'b1;
        ref_idx = IW'(idx);
        step();
        ref_vld = 1'b0;
    endtask

    initial begin
        int r0;
        rst_n = 1'b0; cfg_unit = 2'd0; cfg_age = '0;
        ref_vld = 1'b0; ref_idx = '0; tbl_gnt = 1'b1;
        ml = '0; ld_v = '0; ld_go = 1'b1;
        step(4);
        ld_go = 1'b0;
        rst_n = 1'b1;
        step();
        // R9: reset state
        chk(tbl_req == 1'b0, "R9 req idle", int'(tbl_req), 0);
        chk(tbl_clr == 1'b0, "R9 clr idle", int'(tbl_clr), 0);
        chk(age_o == '0, "R9 age bits", int'(age_o), 0);

        // R1/R2/R3: period spacing with an empty table
        measure(2'd1, 8, 16, "R1 code1 age8 spacing");
        measure(2'd2, 6, 24, "R1 code2 age6 spacing");
        measure(2'd3, 3, 16, "R2 age3 halves to one unit");
        measure(2'd3, 8, 64, "R3 code3 age8 spacing");

        // R2: age 1 and age 0 both disable
        cfg_age = AW'(1);
        step(20);
        r0 = n_rise;
        step(150);
        chk(n_rise == r0, "R2 age1 disables", n_rise - r0, 0);
        cfg_age = AW'(0);
        step(150);
        chk(n_rise == r0, "R2 age0 disables", n_rise - r0, 0);

        // load table: entry 4 invalid, entry 2 locked
        ld_v = 8'b1110_1111; ml = 8'b0000_0100; ld_go = 1'b1;
        step();
        ld_go = 1'b0;
        cfg_unit = 2'd3; cfg_age = AW'(8);
        wait_sweep();
        chk(age_o == 8'b1110_1011, "R4 first sweep marks", int'(age_o), 8'hEB);
        chk(mv == 8'b1110_1111, "R6 nothing removed on first sweep", int'(mv), 8'hEF);

        // R7: refresh clears the bit one edge later
        refresh(1);
        chk(age_o[1] == 1'b0, "R7 refresh entry1", int'(age_o[1]), 0);
        refresh(5);
        chk(age_o == 8'b1100_1001, "R7 refresh entry5", int'(age_o), 8'hC9);

        // R5: second sweep removes the unrefreshed marked entries in order
        exp_q.push_back(0); exp_q.push_back(3); exp_q.push_back(6); exp_q.push_back(7);
        wait_sweep();
        chk(exp_q.size() == 0, "R5 all expected clears seen", exp_q.size(), 0);
        chk(mv == 8'b0010_0110, "R5 table after removal", int'(mv), 8'h26);
        chk(mv[2] == 1'b1, "R6 locked entry kept", int'(mv[2]), 1);
        chk(age_o == 8'b0010_0010, "R4 survivors marked", int'(age_o), 8'h22);

        // R8: third sweep under grant stalls
        refresh(5);
        exp_q.push_back(1);
        visit_q.delete();
        while (!tbl_req) step();
        while (tbl_req) begin
            tbl_gnt = ~tbl_gnt;
            step();
        end
        tbl_gnt = 1'b1;
        chk(visit_q.size() == N, "R8 each entry visited once", visit_q.size(), N);
        for (int i = 0; i < N; i++) begin
            if (i < visit_q.size())
                chk(visit_q[i] == i, "R3 ascending visit order", visit_q[i], i);
        end
        chk(exp_q.size() == 0, "R8 clear issued after stall", exp_q.size(), 0);
        chk(mv == 8'b0010_0100, "R8 table after stalled sweep", int'(mv), 8'h24);
        chk(age_o == 8'b0010_0000, "R6 locked age stays clear", int'(age_o), 8'h20);

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule